// File: doc/BRIEF.md
# TDD Mode and Power-Amplifier Sequencer

This block runs the slot-level control of a time-division-duplex radio. It has two control inputs: a chip-enable line and a receive/transmit select line. From these it derives one of three operating modes: STANDBY, RECEIVE and TRANSMIT. Whenever the receive path is entered, and whenever the channel register is rewritten during receive, it opens a filter-calibration window. Receive data is declared valid only after that window closes.

On the transmit side the block sequences the external power-amplifier enable, the on-chip transmit RF buffer enable and an open-drain transmit-power-control (TPC) pin. The PA enable follows these rules:

- It is withheld for a settling interval at the start of every transmit slot.
- It is cut at once when the PLL reports loss of lock.
- It is cut while a latched low-supply lockout is tripped.
- It drops a fixed lead time before the RF buffer turns off at the end of the slot.

A new TPC level takes effect only at the start of the next transmit slot. All intervals are counted in reference-clock cycles. At the default 12.288 MHz reference, the settling interval is 768 cycles (62.5 µs) and the PA lead is 61 cycles (about 5 µs). All inputs are taken to be synchronous to the reference clock.

The internal states are named as follows:

- **OFF**: standby.
- **RX_CAL**: receive, calibrating.
- **RX_LIVE**: receive, data valid.
- **TX_HOLD**: transmit, PA held off.
- **TX_LIVE**: transmit, PA allowed.
- **TX_TAIL**: transmit, PA off, RF buffer still on.

The transitions are:

- Any state goes to OFF when chip enable is low.
- From OFF, the block goes to RX_CAL if select is high, and to TX_HOLD if select is low.
- From RX_CAL, the block goes to RX_LIVE after the calibration count. It restarts RX_CAL on a channel write.
- From RX_CAL or RX_LIVE, the block goes to TX_HOLD when select goes low.
- From RX_LIVE, the block goes to RX_CAL on a channel write.
- From TX_HOLD, the block goes to TX_LIVE after the hold count.
- From TX_HOLD or TX_LIVE, the block goes to TX_TAIL when select goes high.
- From TX_TAIL, once the lead count ends, the block goes to RX_CAL if select is high, and back to TX_HOLD if select is low.

Top module: `tdd_mode_sequencer`

## Requirements
- R1: The mode output encodes STANDBY=0, RECEIVE=1, TRANSMIT=2. One clock after chip enable is seen low, mode is STANDBY whatever the select input is. With chip enable high, select high leads to RECEIVE and select low leads to TRANSMIT. The mode is registered, one clock after the inputs are seen.
- R2: Every entry into RECEIVE holds cal_busy high for exactly CAL_CYCLES cycles with rx_valid low. rx_valid rises in the following cycle.
- R3: A chan_wr pulse seen in RECEIVE restarts the full CAL_CYCLES window from the next cycle. A chan_wr pulse in TRANSMIT or STANDBY has no effect on any output.
- R4: After each entry into TRANSMIT, pa_en stays low for PA_DELAY_CYCLES cycles and may rise in the next cycle. The RF buffer may already be on during this time.
- R5: pa_en is low in any cycle in which pll_locked is low, in the same cycle.
- R6: When cfg_lvl_en is high, supply_low trips a lockout latch on the next clock, which holds pa_en low. The latch stays set after supply_low returns high-supply. It is cleared only by a rising edge of the select input.
- R7: When select rises during TRANSMIT, pa_en drops on the next clock. The RF buffer stays on for PA_LEAD_CYCLES cycles, and after that the mode becomes RECEIVE with calibration running.
- R8: With cfg_txm=0, txbuf_en is high in every TRANSMIT cycle. With cfg_txm=1, txbuf_en equals pa_en, except during the end-of-slot lead interval, when it stays high.
- R9: With cfg_aout=0, tpc_pull_low is 1 (pin driven low) when the held TPC level is 0, and 0 (high impedance) when it is 1. The held level copies cfg_tpc only on the clock that sees select fall, and its reset value is 1. With cfg_aout=1, tpc_pull_low is always 0.
- R10: Leaving STANDBY, or a select toggle that passes through TRANSMIT, discards any partial calibration. The next RECEIVE entry runs a full CAL_CYCLES window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; low selects STANDBY |
| rx_sel | input | 1 | 1 = receive slot, 0 = transmit slot |
| pll_locked | input | 1 | PLL lock status |
| supply_low | input | 1 | Low-supply comparator output |
| cfg_lvl_en | input | 1 | Enables the low-supply PA lockout |
| cfg_txm | input | 1 | RF buffer policy: 0 = whole slot, 1 = follow PA enable |
| cfg_aout | input | 1 | 1 = pin used as analog output, TPC driver released |
| cfg_tpc | input | 1 | Requested TPC level for the next transmit slot |
| chan_wr | input | 1 | One-cycle pulse on a channel-register write |
| mode | output | 2 | Operating mode (0 standby, 1 receive, 2 transmit) |
| cal_busy | output | 1 | Filter calibration window active |
| rx_valid | output | 1 | Receive data valid |
| pa_en | output | 1 | External power-amplifier enable |
| txbuf_en | output | 1 | Transmit RF buffer enable |
| tpc_pull_low | output | 1 | Open-drain TPC driver active (pin pulled low) |

## Verification
A wrong state or a wrong counter value shows up at the ports within one clock:

- A missed restart of the calibration window makes rx_valid rise too early.
- A wrong transmit hold count moves the pa_en rising edge off its expected cycle.
- A bad tail count changes how long txbuf_en stays high after pa_en drops.

The lockout latch and the held TPC level keep their state across slots. They are therefore checked after their triggering input has been removed, through pa_en staying low and through the TPC pin level persisting into later slots.

// File: rtl/tdd_pkg.sv
package tdd_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY  = 2'd0,
        MODE_RECEIVE  = 2'd1,
        MODE_TRANSMIT = 2'd2
    } tdd_mode_e;

    typedef enum logic [2:0] {
        S_OFF,
        S_RX_CAL,
        S_RX_LIVE,
        S_TX_HOLD,
        S_TX_LIVE,
        S_TX_TAIL
    } tdd_state_e;

endpackage

// File: rtl/tdd_edge_det.sv
module tdd_edge_det #(
    parameter bit RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q <= RESET_LEVEL;
        end else begin
            din_q <= din;
        end
    end

    assign rise = din & ~din_q;
    assign fall = ~din & din_q;
endmodule

// File: rtl/tdd_lvl_latch.sv
module tdd_lvl_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic supply_low,
    input  logic clear,
    output logic tripped
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tripped <= 1'b0;
        end else if (clear) begin
            tripped <= 1'b0;
        end else if (arm && supply_low) begin
            tripped <= 1'b1;
        end
    end
endmodule

// File: rtl/tdd_tpc_hold.sv
module tdd_tpc_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tpc_req,
    input  logic analog_mode,
    output logic pull_low
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
        end else if (load) begin
            level_q <= tpc_req;
        end
    end

    assign pull_low = ~analog_mode & ~level_q;
endmodule

// File: rtl/tdd_slot_fsm.sv
module tdd_slot_fsm
    import tdd_pkg::*;
#(
    parameter int CAL_CYCLES      = 768,
    parameter int PA_DELAY_CYCLES = 768,
    parameter int PA_LEAD_CYCLES  = 61
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       rx_sel,
    input  logic       chan_wr,
    output tdd_state_e state
);
    localparam int MAX_A   = (CAL_CYCLES > PA_DELAY_CYCLES) ? CAL_CYCLES : PA_DELAY_CYCLES;
    localparam int MAX_ALL = (MAX_A > PA_LEAD_CYCLES) ? MAX_A : PA_LEAD_CYCLES;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);
    localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(PA_DELAY_CYCLES - 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(PA_LEAD_CYCLES - 1);

    tdd_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and interval counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + 1'b1;
        if (!chip_en) begin
            st_d  = S_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                S_OFF: begin
                    st_d  = rx_sel ? S_RX_CAL : S_TX_HOLD;
                    cnt_d = '0;
                end
                S_RX_CAL: begin
                    if (!rx_sel) begin
                        st_d  = S_TX_HOLD;
                        cnt_d = '0;
                    end else if (chan_wr) begin
                        st_d  = S_RX_CAL;
                        cnt_d = '0;
                    end else if (cnt_q == CAL_LAST) begin
                        st_d  = S_RX_LIVE;
                        cnt_d = '0;
                    end
                end
                S_RX_LIVE: begin
                    cnt_d = '0;
                    if (!rx_sel) begin
                        st_d = S_TX_HOLD;
                    end else if (chan_wr) begin
                        st_d = S_RX_CAL;
                    end
                end
                S_TX_HOLD: begin
                    if (rx_sel) begin
                        st_d  = S_TX_TAIL;
                        cnt_d = '0;
                    end else if (cnt_q == HOLD_LAST) begin
                        st_d  = S_TX_LIVE;
                        cnt_d = '0;
                    end
                end
                S_TX_LIVE: begin
                    cnt_d = '0;
                    if (rx_sel) begin
                        st_d = S_TX_TAIL;
                    end
                end
                S_TX_TAIL: begin
                    if (cnt_q == LEAD_LAST) begin
                        st_d  = rx_sel ? S_RX_CAL : S_TX_HOLD;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = S_OFF;
                    cnt_d = '0;
                end
            endcase
        end
    end

    assign state = st_q;
endmodule

// File: rtl/tdd_mode_sequencer.sv
module tdd_mode_sequencer
    import tdd_pkg::*;
#(
    parameter int CAL_CYCLES      = 768,
    parameter int PA_DELAY_CYCLES = 768,
    parameter int PA_LEAD_CYCLES  = 61
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       rx_sel,
    input  logic       pll_locked,
    input  logic       supply_low,
    input  logic       cfg_lvl_en,
    input  logic       cfg_txm,
    input  logic       cfg_aout,
    input  logic       cfg_tpc,
    input  logic       chan_wr,
    output logic [1:0] mode,
    output logic       cal_busy,
    output logic       rx_valid,
    output logic       pa_en,
    output logic       txbuf_en,
    output logic       tpc_pull_low
);
    tdd_state_e state;
    logic       sel_rise, sel_fall, lvl_trip;
    logic       pa_ok;

    tdd_slot_fsm #(
        .CAL_CYCLES     (CAL_CYCLES),
        .PA_DELAY_CYCLES(PA_DELAY_CYCLES),
        .PA_LEAD_CYCLES (PA_LEAD_CYCLES)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .chip_en(chip_en),
        .rx_sel (rx_sel),
        .chan_wr(chan_wr),
        .state  (state)
    );

    tdd_edge_det #(.RESET_LEVEL(1'b1)) u_sel_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_sel),
        .rise (sel_rise),
        .fall (sel_fall)
    );

    tdd_lvl_latch u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (cfg_lvl_en),
        .supply_low(supply_low),
        .clear     (sel_rise),
        .tripped   (lvl_trip)
    );

    tdd_tpc_hold u_tpc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sel_fall),
        .tpc_req    (cfg_tpc),
        .analog_mode(cfg_aout),
        .pull_low   (tpc_pull_low)
    );

    assign pa_ok = pll_locked & ~lvl_trip;

    // Output decode
    always_comb begin
        mode     = MODE_STANDBY;
        cal_busy = 1'b0;
        rx_valid = 1'b0;
        pa_en    = 1'b0;
        txbuf_en = 1'b0;
        unique case (state)
            S_OFF: begin
                mode = MODE_STANDBY;
            end
            S_RX_CAL: begin
                mode     = MODE_RECEIVE;
                cal_busy = 1'b1;
            end
            S_RX_LIVE: begin
                mode     = MODE_RECEIVE;
                rx_valid = 1'b1;
            end
            S_TX_HOLD: begin
                mode     = MODE_TRANSMIT;
                txbuf_en = ~cfg_txm;
            end
            S_TX_LIVE: begin
                mode     = MODE_TRANSMIT;
                pa_en    = pa_ok;
                txbuf_en = cfg_txm ? pa_ok : 1'b1;
            end
            S_TX_TAIL: begin
                mode     = MODE_TRANSMIT;
                txbuf_en = 1'b1;
            end
            default: begin
                mode = MODE_STANDBY;
            end
        endcase
    end
endmodule

// File: rtl/tdd_mode_sequencer_chk.sv
module tdd_mode_sequencer_chk
    import tdd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       chip_en,
    input logic       rx_sel,
    input logic       pll_locked,
    input logic       supply_low,
    input logic       cfg_lvl_en,
    input logic       cfg_txm,
    input logic       cfg_aout,
    input logic       chan_wr,
    input logic [1:0] mode,
    input logic       cal_busy,
    input logic       rx_valid,
    input logic       pa_en,
    input logic       txbuf_en,
    input logic       tpc_pull_low
);
    a_r1_standby_next: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (mode == MODE_STANDBY));

    a_r1_pa_only_tx: assert property (@(posedge clk) disable iff (!rst_n)
        pa_en |-> (mode == MODE_TRANSMIT));

    a_r2_valid_after_cal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(cal_busy));

    a_r2_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!cal_busy && mode == MODE_RECEIVE));

    a_r3_chan_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && rx_sel && chan_wr && mode == MODE_RECEIVE) |=> cal_busy);

    a_r4_pa_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_sel) && chip_en) |=> !pa_en);

    a_r5_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |-> !pa_en);

    a_r6_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lvl_en && supply_low) |=> !pa_en);

    a_r8_buf_full: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TRANSMIT && !cfg_txm) |-> txbuf_en);

    a_r8_buf_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_txm && pa_en) |-> txbuf_en);

    a_r8_buf_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
        txbuf_en |-> (mode == MODE_TRANSMIT));

    a_r9_analog_release: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_aout |-> !tpc_pull_low);
endmodule

bind tdd_mode_sequencer tdd_mode_sequencer_chk u_chk (.*);

// File: tb/sim_tdd_mode_sequencer.sv
module sim_tdd_mode_sequencer;
    localparam int CAL  = 20;
    localparam int PAD  = 16;
    localparam int LEAD = 5;

    localparam logic [6:0] B_M = 7'b1100000;
    localparam logic [6:0] B_C = 7'b0010000;
    localparam logic [6:0] B_V = 7'b0001000;
    localparam logic [6:0] B_P = 7'b0000100;
    localparam logic [6:0] B_B = 7'b0000010;
    localparam logic [6:0] B_T = 7'b0000001;
    localparam logic [6:0] B_ALL = 7'b1111111;

    localparam logic [1:0] MS = 2'd0;
    localparam logic [1:0] MR = 2'd1;
    localparam logic [1:0] MT = 2'd2;

    typedef struct {
        int         at;
        logic [6:0] mask;
        logic [6:0] val;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic chip_en = 1'b0, rx_sel = 1'b1, pll_locked = 1'b1, supply_low = 1'b0;
    logic cfg_lvl_en = 1'b0, cfg_txm = 1'b0, cfg_aout = 1'b0, cfg_tpc = 1'b1, chan_wr = 1'b0;
    logic [1:0] mode;
    logic cal_busy, rx_valid, pa_en, txbuf_en, tpc_pull_low;
    logic [6:0] obs;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    exp_t q[$];

    tdd_mode_sequencer #(
        .CAL_CYCLES     (CAL),
        .PA_DELAY_CYCLES(PAD),
        .PA_LEAD_CYCLES (LEAD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .rx_sel(rx_sel),
        .pll_locked(pll_locked), .supply_low(supply_low), .cfg_lvl_en(cfg_lvl_en),
        .cfg_txm(cfg_txm), .cfg_aout(cfg_aout), .cfg_tpc(cfg_tpc), .chan_wr(chan_wr),
        .mode(mode), .cal_busy(cal_busy), .rx_valid(rx_valid), .pa_en(pa_en),
        .txbuf_en(txbuf_en), .tpc_pull_low(tpc_pull_low)
    );

    assign obs = {mode, cal_busy, rx_valid, pa_en, txbuf_en, tpc_pull_low};

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [6:0] pk(logic [1:0] m, logic c, logic v, logic p, logic b, logic t);
        return {m, c, v, p, b, t};
    endfunction

    task automatic expect_at(int dly, logic [6:0] mask, logic [6:0] val, string tag);
        exp_t e;
        e.at   = cyc + dly;
        e.mask = mask;
        e.val  = val & mask;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare scoreboard entries due in this cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at <= cyc) begin
                checks++;
                if ((obs & q[i].mask) !== q[i].val) begin
                    failures++;
                    $display("FAIL %s cycle=%0d actual=%b expected=%b mask=%b",
                             q[i].tag, cyc, obs & q[i].mask, q[i].val, q[i].mask);
                end
                q.delete(i);
            end
        end
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        expect_at(0, B_ALL, pk(MS, 0, 0, 0, 0, 0), "R1 reset state");
        step(2);
        rst_n = 1'b1;
        step(2);
        expect_at(0, B_ALL, pk(MS, 0, 0, 0, 0, 0), "R1 standby after reset");
        step(1);

        // R2: entry into receive
        chip_en = 1'b1;
        expect_at(1, B_M | B_C | B_V, pk(MR, 1, 0, 0, 0, 0), "R1 R2 receive entry");
        expect_at(CAL, B_C | B_V, pk(MS, 1, 0, 0, 0, 0), "R2 last busy cycle");
        expect_at(CAL + 1, B_M | B_C | B_V, pk(MR, 0, 1, 0, 0, 0), "R2 valid after window");
        step(CAL + 4);

        // R3: channel write restarts window
        chan_wr = 1'b1;
        expect_at(1, B_C | B_V, pk(MS, 1, 0, 0, 0, 0), "R3 restart");
        expect_at(CAL, B_C, pk(MS, 1, 0, 0, 0, 0), "R3 full window");
        expect_at(CAL + 1, B_C | B_V, pk(MS, 0, 1, 0, 0, 0), "R3 valid again");
        step(1);
        chan_wr = 1'b0;
        step(CAL + 3);

        // R10: standby during calibration discards progress
        chan_wr = 1'b1;
        step(1);
        chan_wr = 1'b0;
        step(4);
        chip_en = 1'b0;
        expect_at(1, B_M | B_C, pk(MS, 0, 0, 0, 0, 0), "R1 standby overrides select");
        step(2);
        chip_en = 1'b1;
        expect_at(1, B_M | B_C | B_V, pk(MR, 1, 0, 0, 0, 0), "R10 fresh window");
        expect_at(CAL, B_C, pk(MS, 1, 0, 0, 0, 0), "R10 still busy");
        expect_at(CAL + 1, B_C | B_V, pk(MS, 0, 1, 0, 0, 0), "R10 valid");
        step(CAL + 3);

        // R10: select toggle during calibration
        chan_wr = 1'b1;
        step(1);
        chan_wr = 1'b0;
        step(3);
        rx_sel = 1'b0;
        step(1);
        rx_sel = 1'b1;
        expect_at(LEAD + 1, B_M | B_C, pk(MR, 1, 0, 0, 0, 0), "R10 toggle restart");
        expect_at(LEAD + CAL, B_C | B_V, pk(MS, 1, 0, 0, 0, 0), "R10 toggle busy");
        expect_at(LEAD + CAL + 1, B_C | B_V, pk(MS, 0, 1, 0, 0, 0), "R10 toggle valid");
        step(LEAD + CAL + 4);

        // R4 / R8 (txm=0): transmit entry
        rx_sel = 1'b0;
        expect_at(1, B_M | B_C | B_V | B_P | B_B, pk(MT, 0, 0, 0, 1, 0), "R4 R8 tx entry");
        expect_at(PAD, B_P | B_B, pk(MS, 0, 0, 0, 1, 0), "R4 pa still held");
        expect_at(PAD + 1, B_P | B_B, pk(MS, 0, 0, 1, 1, 0), "R4 pa released");
        step(PAD + 3);

        // R5: lock loss
        pll_locked = 1'b0;
        expect_at(0, B_P | B_B, pk(MS, 0, 0, 0, 1, 0), "R5 unlock gates pa");
        step(3);
        pll_locked = 1'b1;
        expect_at(0, B_P, pk(MS, 0, 0, 1, 0, 0), "R5 relock");
        step(2);

        // R3: channel write in transmit is ignored
        chan_wr = 1'b1;
        expect_at(1, B_M | B_C | B_P, pk(MT, 0, 0, 1, 0, 0), "R3 ignored in tx");
        step(1);
        chan_wr = 1'b0;
        expect_at(2, B_M | B_C | B_P, pk(MT, 0, 0, 1, 0, 0), "R3 ignored after");
        step(3);

        // R6: lockout latch
        cfg_lvl_en = 1'b1;
        supply_low = 1'b1;
        expect_at(1, B_P | B_B, pk(MS, 0, 0, 0, 1, 0), "R6 lockout trips");
        step(1);
        supply_low = 1'b0;
        expect_at(3, B_P, pk(MS, 0, 0, 0, 0, 0), "R6 latch holds");
        step(4);

        // R7: end of transmit slot
        rx_sel = 1'b1;
        expect_at(1, B_M | B_P | B_B, pk(MT, 0, 0, 0, 1, 0), "R7 tail start");
        expect_at(LEAD, B_M | B_B, pk(MT, 0, 0, 0, 1, 0), "R7 tail end");
        expect_at(LEAD + 1, B_M | B_C | B_B, pk(MR, 1, 0, 0, 0, 0), "R7 back to receive");
        step(LEAD + CAL + 4);

        // R6: latch cleared by select rise
        rx_sel = 1'b0;
        expect_at(PAD + 1, B_P, pk(MS, 0, 0, 1, 0, 0), "R6 latch cleared");
        step(PAD + 3);
        rx_sel = 1'b1;
        step(LEAD + CAL + 4);
        cfg_lvl_en = 1'b0;

        // R8: buffer follows PA with txm=1
        cfg_txm = 1'b1;
        rx_sel = 1'b0;
        expect_at(1, B_M | B_P | B_B, pk(MT, 0, 0, 0, 0, 0), "R8 buffer off in hold");
        expect_at(PAD + 1, B_P | B_B, pk(MS, 0, 0, 1, 1, 0), "R8 buffer with pa");
        step(PAD + 3);
        pll_locked = 1'b0;
        expect_at(0, B_P | B_B, pk(MS, 0, 0, 0, 0, 0), "R8 buffer follows unlock");
        step(2);
        pll_locked = 1'b1;
        step(1);
        rx_sel = 1'b1;
        expect_at(1, B_P | B_B, pk(MS, 0, 0, 0, 1, 0), "R7 R8 lead buffer on");
        expect_at(LEAD, B_B, pk(MS, 0, 0, 0, 1, 0), "R7 lead last");
        expect_at(LEAD + 1, B_M | B_B, pk(MR, 0, 0, 0, 0, 0), "R7 buffer off");
        step(LEAD + CAL + 4);
        cfg_txm = 1'b0;

        // R9: deferred TPC
        cfg_tpc = 1'b0;
        expect_at(2, B_T, pk(MS, 0, 0, 0, 0, 0), "R9 deferred");
        step(3);
        rx_sel = 1'b0;
        expect_at(1, B_T, pk(MS, 0, 0, 0, 0, 1), "R9 applied at fall");
        step(2);
        cfg_tpc = 1'b1;
        expect_at(2, B_T, pk(MS, 0, 0, 0, 0, 1), "R9 held in slot");
        step(3);
        cfg_aout = 1'b1;
        expect_at(0, B_T, pk(MS, 0, 0, 0, 0, 0), "R9 analog releases");
        step(2);
        cfg_aout = 1'b0;
        expect_at(0, B_T, pk(MS, 0, 0, 0, 0, 1), "R9 held level returns");
        step(2);
        rx_sel = 1'b1;
        step(3);
        rx_sel = 1'b0;
        expect_at(1, B_T, pk(MS, 0, 0, 0, 0, 0), "R9 released next slot");
        step(5);

        if (q.size() != 0) begin
            failures++;
            $display("FAIL R1 pending entries actual=%0d expected=0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule